// File: doc/BRIEF.md
# Hot-Plug Slot Event Notifier

This block holds the slot control and slot status registers of a hot-plug capable downstream port. It also holds the logic that turns slot events into interrupts. Single-cycle event strobes from the slot set sticky status bits. Software clears those bits by writing ones. Software sets per-event enable bits and a master enable through a byte-enabled register-write port. Both registers are always visible on read-back outputs.

From the control and status registers the block computes one notification condition and keeps a registered copy of it. Hardware events and software writes both feed that condition in the same way. This includes a write that unmasks an event already latched. The `msi_en` input selects how the condition is signalled:

- With `msi_en` low, a level-sensitive legacy interrupt line follows the condition.
- With `msi_en` high, a one-cycle message-interrupt request pulse is issued each time the condition turns from false to true.

Top module: `hp_slot_notifier`

## Requirements
- R1: After reset the slot control register, the slot status register, `intx_o` and `msi_req_o` are all zero.
- R2: An event strobe on `ev_in[i]` for a supported event sets status bit i on the next clock edge. The bit stays set until software clears it. Status bit positions are: 0 button pressed, 1 power fault, 2 latch sensor changed, 3 presence changed, 4 command completed.
- R3: A status write (`wr_sel`=1) clears each status bit whose data bit is 1 and whose byte lane is enabled. Data bits of 0, and bytes whose `wr_be` bit is 0, leave status unchanged.
- R4: If an event strobe and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R5: A control write (`wr_sel`=0) replaces the control bits lying in enabled byte lanes. Bits 0 to 4 are the per-event enables and bit 5 is the master enable. All other bits are not implemented and read as zero.
- R6: The notification condition is true exactly when the master enable is set and some supported event has both its status bit and its enable bit set.
- R7: With `msi_en` low, `intx_o` equals the condition computed from the register values of the previous cycle. It therefore rises or falls one cycle after the register update that changes the condition.
- R8: With `msi_en` high, `msi_req_o` pulses high for exactly one cycle, one cycle after the condition turns true. Nothing is issued when the condition turns false.
- R9: An event whose status bit is already set produces no new message request.
- R10: An event latched while masked raises a notification one cycle after a control write makes the condition true.
- R11: While `msi_en` is high, `intx_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects slot control, 1 selects slot status |
| wr_be | input | 2 | Byte enables for the write data |
| wr_data | input | 16 | Write data |
| ev_in | input | 5 | Slot event strobes, one per event |
| msi_en | input | 1 | Selects message interrupts instead of the legacy line |
| slot_ctl_o | output | 6 | Slot control read-back |
| slot_sts_o | output | 5 | Slot status read-back |
| intx_o | output | 1 | Level-sensitive legacy interrupt |
| msi_req_o | output | 1 | One-cycle message-interrupt request |

## Verification
The hardest case to reach is a notification that a control write causes rather than an event. Here an event was latched earlier while masked, and no further event arrives. The bench strobes a presence change while every enable is clear and watches several quiet cycles. It then writes the master and matching enable together and expects the request pulse one cycle later. The other hard case is a collision: the bench fires an event strobe in the very cycle that a clearing write targets the same bit.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

    typedef enum logic {
        SEL_CTL = 1'b0,
        SEL_STS = 1'b1
    } hp_reg_sel_e;

    typedef struct packed {
        logic cond;
        logic intx;
        logic msi_req;
    } hp_note_t;

endpackage

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
    import hp_slot_pkg::*;
#(
    parameter int              NUM_EV   = 5,
    parameter int              DATA_W   = 16,
    parameter logic [NUM_EV-1:0] SUP_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NUM_EV-1:0] ev_in,
    output logic [NUM_EV:0]   ctl_o,
    output logic [NUM_EV-1:0] sts_o
);
    localparam int NUM_BYTES = DATA_W / 8;
    localparam int CTL_W     = NUM_EV + 1;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [NUM_EV-1:0] sts;
    } slot_regs_t;

    slot_regs_t        r_d, r_q;
    logic [DATA_W-1:0] lane_msk;
    logic [NUM_EV-1:0] clr_bits;
    logic              ctl_wr, sts_wr;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
        assign lane_msk[b*8 +: 8] = {8{wr_be[b]}};
    end

    always_comb begin
        r_d      = r_q;
        ctl_wr   = wr_en && (hp_reg_sel_e'(wr_sel) == SEL_CTL);
        sts_wr   = wr_en && (hp_reg_sel_e'(wr_sel) == SEL_STS);
        clr_bits = sts_wr ? (wr_data[NUM_EV-1:0] & lane_msk[NUM_EV-1:0] & SUP_MASK)
                          : '0;
        if (ctl_wr) begin
            r_d.ctl = (r_q.ctl & ~lane_msk[CTL_W-1:0])
                    | (wr_data[CTL_W-1:0] & lane_msk[CTL_W-1:0]);
        end
        // a new event wins over a same-cycle clear
        r_d.sts = ((r_q.sts & ~clr_bits) | ev_in) & SUP_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctl_o = r_q.ctl;
    assign sts_o = r_q.sts;

    for (genvar i = 0; i < NUM_EV; i++) begin : g_chk
        localparam int LANE = i / 8;
        if (SUP_MASK[i]) begin : g_sup
            assert_ev_sets_R2 : assert property (@(posedge clk) disable iff (!rst_n)
                ev_in[i] |=> sts_o[i]);
            assert_sticky_R3 : assert property (@(posedge clk) disable iff (!rst_n)
                (sts_o[i] && !(wr_en && wr_sel && wr_be[LANE] && wr_data[i]))
                |=> sts_o[i]);
            assert_w1c_R3 : assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_sel && wr_be[LANE] && wr_data[i] && !ev_in[i])
                |=> !sts_o[i]);
        end
    end
endmodule

// File: rtl/hp_notify_eval.sv
module hp_notify_eval
    import hp_slot_pkg::*;
#(
    parameter int                NUM_EV   = 5,
    parameter logic [NUM_EV-1:0] SUP_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV:0]   ctl_i,
    input  logic [NUM_EV-1:0] sts_i,
    input  logic              msi_en,
    output logic              intx_o,
    output logic              msi_req_o
);
    localparam int MASTER_BIT = NUM_EV;

    hp_note_t n_d, n_q;
    logic     cond_now;

    always_comb begin
        cond_now    = ctl_i[MASTER_BIT] && |(ctl_i[NUM_EV-1:0] & sts_i & SUP_MASK);
        n_d         = n_q;
        n_d.cond    = cond_now;
        n_d.intx    = !msi_en && cond_now;
        n_d.msi_req = msi_en && cond_now && !n_q.cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end

    assign intx_o    = n_q.intx;
    assign msi_req_o = n_q.msi_req;

    assert_msi_single_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        msi_req_o |=> !msi_req_o);
    assert_msi_on_rise_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        msi_req_o |-> (n_q.cond && !$past(n_q.cond)));
    assert_no_repeat_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (n_q.cond && $stable(ctl_i)) |=> !msi_req_o);
    assert_intx_quiet_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        msi_en |=> !intx_o);
endmodule

// File: rtl/hp_slot_notifier.sv
module hp_slot_notifier
    import hp_slot_pkg::*;
#(
    parameter int                NUM_EV   = 5,
    parameter int                DATA_W   = 16,
    parameter logic [NUM_EV-1:0] SUP_MASK = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [NUM_EV-1:0]   ev_in,
    input  logic                msi_en,
    output logic [NUM_EV:0]     slot_ctl_o,
    output logic [NUM_EV-1:0]   slot_sts_o,
    output logic                intx_o,
    output logic                msi_req_o
);
    logic [NUM_EV:0]   ctl_w;
    logic [NUM_EV-1:0] sts_w;

    hp_slot_regs #(.NUM_EV(NUM_EV), .DATA_W(DATA_W), .SUP_MASK(SUP_MASK)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .ev_in   (ev_in),
        .ctl_o   (ctl_w),
        .sts_o   (sts_w)
    );

    hp_notify_eval #(.NUM_EV(NUM_EV), .SUP_MASK(SUP_MASK)) u_eval (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_i     (ctl_w),
        .sts_i     (sts_w),
        .msi_en    (msi_en),
        .intx_o    (intx_o),
        .msi_req_o (msi_req_o)
    );

    assign slot_ctl_o = ctl_w;
    assign slot_sts_o = sts_w;

    assert_outputs_exclusive_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        !(intx_o && msi_req_o));
endmodule

// File: tb/hp_slot_notifier_test.sv
module hp_slot_notifier_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [1:0]  wr_be = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  ev_in = '0;
    logic        msi_en = 1'b0;
    logic [5:0]  slot_ctl_o;
    logic [4:0]  slot_sts_o;
    logic        intx_o;
    logic        msi_req_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hp_slot_notifier uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
        .wr_data(wr_data), .ev_in(ev_in), .msi_en(msi_en), .slot_ctl_o(slot_ctl_o),
        .slot_sts_o(slot_sts_o), .intx_o(intx_o), .msi_req_o(msi_req_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [15:0] data, input logic [1:0] be);
        wr_en = 1'b1; wr_sel = sel; wr_data = data; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; wr_be = '0;
    endtask

    task automatic fire(input logic [4:0] m);
        ev_in = m;
        @(negedge clk);
        ev_in = '0;
    endtask

    task automatic idle_no_msi(input string req, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(req, 16'(msi_req_o), 16'h0);
        end
    endtask

    task automatic clear_all();
        reg_write(1'b1, 16'h001F, 2'b01);
        reg_write(1'b0, 16'h0000, 2'b11);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ctl", 16'(slot_ctl_o), 16'h0);
        chk("R1 sts", 16'(slot_sts_o), 16'h0);
        chk("R1 intx", 16'(intx_o), 16'h0);
        chk("R1 msi", 16'(msi_req_o), 16'h0);
    endtask

    task automatic t_sticky();
        fire(5'h08);
        chk("R2 set", 16'(slot_sts_o), 16'h08);
        repeat (3) @(negedge clk);
        chk("R2 sticky", 16'(slot_sts_o), 16'h08);
        chk("R6 masked intx", 16'(intx_o), 16'h0);
    endtask

    task automatic t_w1c();
        reg_write(1'b1, 16'h0000, 2'b01);
        chk("R3 zero write", 16'(slot_sts_o), 16'h08);
        reg_write(1'b1, 16'h0008, 2'b10);
        chk("R3 lane off", 16'(slot_sts_o), 16'h08);
        reg_write(1'b1, 16'h0008, 2'b01);
        chk("R3 clear", 16'(slot_sts_o), 16'h00);
    endtask

    task automatic t_collide();
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'h0001; wr_be = 2'b01; ev_in = 5'h01;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; wr_be = '0; ev_in = '0;
        chk("R4 event wins", 16'(slot_sts_o), 16'h01);
        clear_all();
    endtask

    task automatic t_ctl();
        reg_write(1'b0, 16'hFFFF, 2'b11);
        chk("R5 implemented bits", 16'(slot_ctl_o), 16'h003F);
        reg_write(1'b0, 16'h0000, 2'b10);
        chk("R5 lane off", 16'(slot_ctl_o), 16'h003F);
        reg_write(1'b0, 16'h0012, 2'b01);
        chk("R5 replace", 16'(slot_ctl_o), 16'h0012);
        clear_all();
    endtask

    task automatic t_intx();
        msi_en = 1'b0;
        reg_write(1'b0, 16'h0001, 2'b01);  // enable without master
        fire(5'h01);
        @(negedge clk);
        chk("R6 no master", 16'(intx_o), 16'h0);
        reg_write(1'b0, 16'h0021, 2'b01);
        chk("R7 latency", 16'(intx_o), 16'h0);
        @(negedge clk);
        chk("R7 rise", 16'(intx_o), 16'h1);
        fire(5'h02);                       // power fault, not enabled
        reg_write(1'b1, 16'h0001, 2'b01);
        chk("R3 partial clear", 16'(slot_sts_o), 16'h02);
        chk("R7 hold", 16'(intx_o), 16'h1);
        @(negedge clk);
        chk("R6 other bit unenabled", 16'(intx_o), 16'h0);
        chk("R7 msi quiet", 16'(msi_req_o), 16'h0);
        clear_all();
    endtask

    task automatic t_msi();
        msi_en = 1'b1;
        reg_write(1'b0, 16'h0030, 2'b01);
        fire(5'h10);
        chk("R8 before", 16'(msi_req_o), 16'h0);
        @(negedge clk);
        chk("R8 pulse", 16'(msi_req_o), 16'h1);
        chk("R11 intx low", 16'(intx_o), 16'h0);
        @(negedge clk);
        chk("R8 one cycle", 16'(msi_req_o), 16'h0);
        fire(5'h10);
        idle_no_msi("R9 repeat event", 3);
        reg_write(1'b1, 16'h0010, 2'b01);
        idle_no_msi("R8 falling", 3);
        clear_all();
    endtask

    task automatic t_unmask();
        msi_en = 1'b1;
        fire(5'h08);
        idle_no_msi("R10 masked", 3);
        reg_write(1'b0, 16'h0028, 2'b01);
        chk("R10 before", 16'(msi_req_o), 16'h0);
        @(negedge clk);
        chk("R10 pulse", 16'(msi_req_o), 16'h1);
        @(negedge clk);
        chk("R10 single", 16'(msi_req_o), 16'h0);
    endtask

    task automatic t_reset_again();
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_sticky();
        t_w1c();
        t_collide();
        t_ctl();
        t_intx();
        t_msi();
        t_unmask();
        t_reset_again();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule